// File: doc/BRIEF.md
# SDR SDRAM Command Bus Checker

This block watches the command pins of a four-bank single-data-rate SDRAM, one sample per clock. It turns the clock-enable pair, chip select, the three strobes, the bank address and the auto-precharge address bit into a command code, and follows the open or closed state of every bank. It also follows the data burst in flight and the timing windows that the command bus must respect. The first rule that is broken raises a sticky error flag and records a code that names the rule. From the DQM pin it derives a same-cycle write-data mask and a read-data high-impedance strobe.

It is meant to sit in parallel with a memory controller, either in a simulation environment or as an on-chip protocol guard. It never drives the memory bus. A command that breaks a rule is reported and otherwise dropped, so the banks and bursts it tracks keep showing the state the memory itself would hold.

Top module: `sdram_cmd_checker`

## Requirements
- R1: With clock enable high in the previous and the present cycle and chip select low, the strobe levels {RAS#,CAS#,WE#} give `cmd` as follows: 000 mode set = 2, 001 refresh = 3, 011 activate = 4, 101 read = 5, 100 write = 6, 110 burst stop = 7, 010 precharge = 8, 111 NOP = 1. With chip select high the code is 0 (deselect), which is always legal. Self-refresh entry is 9, self-refresh exit is 10, and any other clock-enable combination is 11.
- R2: The bank index is {BA0,BA1}: `ba`=00 selects bank bit 0, `ba`=10 selects bit 1, `ba`=01 selects bit 2 and `ba`=11 selects bit 3 of `bank_open`. An activate sets that bit one cycle later.
- R3: A precharge with `a10` high clears every bit of `bank_open` and ignores `ba`. With `a10` low it clears only the addressed bank.
- R4: A mode set, a refresh or a self-refresh entry while any bank is open is an error with code 1. With all banks closed the same commands are legal.
- R5: During the two cycles after a legal mode set, any command other than NOP or deselect is an error with code 2. The third cycle after it is free.
- R6: While a read or write burst with auto precharge is running, any read or write is an error with code 3. The bank of that burst stays open until the burst ends, then closes, and a read or write to another bank is legal in the very next cycle.
- R7: An activate to the bank closed by an auto-precharge burst within TRP cycles after the burst ends is an error with code 4. The first legal cycle is TRP cycles after the end.
- R8: A read or write to a closed bank is an error with code 5. An activate to an open bank is an error with code 6.
- R9: `err` and `err_code` are cleared by reset. Once `err` is set it stays set and `err_code` keeps the first code. A command flagged as an error changes no tracked state.
- R10: `wr_mask` equals `dqm` in every cycle of a write burst, from the write command through the last beat, and is 0 outside write bursts.
- R11: `rd_hiz` is high exactly two cycles after a read-burst cycle in which `dqm` was high. A high `dqm` outside a read burst never raises it.
- R12: A legal mode set takes the burst length from `addr_lo`: 0→1, 1→2, 2→4, any other value→8. The length after reset is 1.
- R13: Self-refresh entry is the refresh encoding sampled with clock enable falling. Exit is clock enable rising while in self refresh. An exit carrying anything other than NOP or deselect is an error with code 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_prev | input | 1 | Clock enable sampled in the previous cycle |
| cke | input | 1 | Clock enable in the present cycle |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address {BA1,BA0} |
| a10 | input | 1 | Auto-precharge / all-banks address bit |
| addr_lo | input | 3 | Low address bits, burst-length key at mode set |
| dqm | input | 1 | Data mask pin |
| cmd | output | 4 | Decoded command code (R1) |
| err | output | 1 | Sticky protocol error flag |
| err_code | output | 3 | Code of the first error |
| bank_open | output | 4 | Per-bank open flags |
| wr_mask | output | 1 | Write data mask for this cycle |
| rd_hiz | output | 1 | Read data high-impedance for this cycle |

## Verification
The tightest overlap is the last beat of an auto-precharge burst against the command that follows it. In the edge that ends the burst the bank closes and the TRP window opens, so a read to another bank in the next cycle must be accepted. The same window still blocks an activate of the closed bank. The bench places a read in the first cycle after a four-beat auto-precharge read, then an activate exactly TRP cycles later, and expects no error from either. A write issued one beat into the next auto-precharge burst must then give code 3. A second overlap is DQM acting on two latencies at once: during a read burst that follows a write burst, the bench checks in each cycle that the write mask follows DQM only inside the write beats, and that the high-impedance strobe follows DQM from two cycles earlier.

// File: rtl/sdram_cmd_checker.sv
module sdram_cmd_checker #(
  parameter int TRP = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cke_prev,
  input  logic       cke,
  input  logic       cs_n,
  input  logic       ras_n,
  input  logic       cas_n,
  input  logic       we_n,
  input  logic [1:0] ba,
  input  logic       a10,
  input  logic [2:0] addr_lo,
  input  logic       dqm,
  output logic [3:0] cmd,
  output logic       err,
  output logic [2:0] err_code,
  output logic [3:0] bank_open,
  output logic       wr_mask,
  output logic       rd_hiz
);

  localparam int TW = $clog2(TRP + 1);
  localparam logic [3:0] C_DES = 4'd0, C_NOP = 4'd1, C_MRS = 4'd2, C_REF = 4'd3,
                         C_ACT = 4'd4, C_RD = 4'd5, C_WR = 4'd6, C_BST = 4'd7,
                         C_PRE = 4'd8, C_SIN = 4'd9, C_SOUT = 4'd10, C_OTH = 4'd11;

  logic [1:0]    lock;
  logic [TW-1:0] trp_cnt;
  logic [1:0]    trp_bank;
  logic [2:0]    bl_sel;
  logic [2:0]    b_left;
  logic          b_wr, b_ap;
  logic [1:0]    b_bank;
  logic          in_sref;
  logic          rd_q1, rd_q2;
  logic [2:0]    e_code;
  logic [3:0]    blen;

  wire [2:0] pins    = {ras_n, cas_n, we_n};
  wire [1:0] bk      = {ba[0], ba[1]};
  wire       all_idle = (bank_open == 4'd0);
  wire       is_rw   = (cmd == C_RD) || (cmd == C_WR);
  wire       ap_busy = b_ap && (b_left != 3'd0);
  wire       nopish  = (cmd == C_DES) || (cmd == C_NOP);
  wire       exit_ok = cs_n || (pins == 3'b111);
  wire       bad     = (e_code != 3'd0);
  wire       rd_cyc  = (cmd == C_RD) || ((b_left != 3'd0) && !b_wr && (cmd != C_WR));
  wire       wr_cyc  = (cmd == C_WR) || ((b_left != 3'd0) && b_wr && (cmd != C_RD));

  assign wr_mask = dqm && wr_cyc;
  assign rd_hiz  = rd_q2;

  always_comb begin
    case (bl_sel)
      3'd0:    blen = 4'd1;
      3'd1:    blen = 4'd2;
      3'd2:    blen = 4'd4;
      default: blen = 4'd8;
    endcase
  end

  always_comb begin
    cmd = C_OTH;
    if (cke_prev && cke) begin
      if (cs_n) cmd = C_DES;
      else begin
        case (pins)
          3'b000:  cmd = C_MRS;
          3'b001:  cmd = C_REF;
          3'b011:  cmd = C_ACT;
          3'b101:  cmd = C_RD;
          3'b100:  cmd = C_WR;
          3'b110:  cmd = C_BST;
          3'b010:  cmd = C_PRE;
          default: cmd = C_NOP;
        endcase
      end
    end else if (cke_prev && !cke && !cs_n && pins == 3'b001) cmd = C_SIN;
    else if (!cke_prev && cke && in_sref) cmd = C_SOUT;
  end

  always_comb begin
    e_code = 3'd0;
    if (lock != 2'd0 && !nopish && cmd != C_OTH)                         e_code = 3'd2;
    else if ((cmd == C_MRS || cmd == C_REF || cmd == C_SIN) && !all_idle) e_code = 3'd1;
    else if (is_rw && ap_busy)                                           e_code = 3'd3;
    else if (cmd == C_ACT && trp_cnt != '0 && trp_bank == bk)            e_code = 3'd4;
    else if (is_rw && !bank_open[bk])                                    e_code = 3'd5;
    else if (cmd == C_ACT && bank_open[bk])                              e_code = 3'd6;
    else if (cmd == C_SOUT && !exit_ok)                                  e_code = 3'd7;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err <= 1'b0; err_code <= 3'd0; bank_open <= 4'd0;
      lock <= 2'd0; trp_cnt <= '0; trp_bank <= 2'd0; bl_sel <= 3'd0;
      b_left <= 3'd0; b_wr <= 1'b0; b_ap <= 1'b0; b_bank <= 2'd0;
      in_sref <= 1'b0; rd_q1 <= 1'b0; rd_q2 <= 1'b0;
    end else begin
      if (bad && !err) begin
        err      <= 1'b1;
        err_code <= e_code;
      end
      rd_q1 <= dqm && rd_cyc;
      rd_q2 <= rd_q1;
      if (lock != 2'd0)    lock    <= lock - 2'd1;
      if (trp_cnt != '0)   trp_cnt <= trp_cnt - TW'(1);
      if (b_left != 3'd0)  b_left  <= b_left - 3'd1;
      if (ap_busy && b_left == 3'd1) begin
        bank_open[b_bank] <= 1'b0;
        trp_cnt  <= TW'(TRP);
        trp_bank <= b_bank;
      end
      if (cmd == C_SOUT) in_sref <= 1'b0;
      if (!bad) begin
        case (cmd)
          C_MRS: begin
            bl_sel <= addr_lo;
            lock   <= 2'd2;
          end
          C_ACT: bank_open[bk] <= 1'b1;
          C_PRE: begin
            if (a10) bank_open <= 4'd0;
            else     bank_open[bk] <= 1'b0;
          end
          C_RD, C_WR: begin
            b_left <= 3'(blen - 4'd1);
            b_wr   <= (cmd == C_WR);
            b_ap   <= a10;
            b_bank <= bk;
            if (a10 && blen == 4'd1) begin
              bank_open[bk] <= 1'b0;
              trp_cnt  <= TW'(TRP);
              trp_bank <= bk;
            end
          end
          C_BST: begin
            b_left <= 3'd0;
            if (ap_busy) begin
              bank_open[b_bank] <= 1'b0;
              trp_cnt  <= TW'(TRP);
              trp_bank <= b_bank;
            end
          end
          C_SIN:   in_sref <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  // R9
  sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> (err && $stable(err_code)));

  // R4
  mrs_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_MRS && bank_open != 4'd0) |=> err);

  // R8
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == C_RD && bank_open == 4'd0) |=> err);

  // R10
  wr_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |-> dqm);

  // R11
  rd_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hiz |-> $past(dqm, 2));

endmodule

// File: tb/sdram_cmd_checker_bench.sv
module sdram_cmd_checker_bench;

  localparam int DES = 0, NOP = 1, MRS = 2, REF = 3, ACT = 4, RD = 5, WR = 6,
                 BST = 7, PRE = 8, SIN = 9, SOUT = 10, OTH = 11, SOUT_BAD = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke_prev = 1'b1, cke = 1'b1, cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = 2'd0;
  logic a10 = 1'b0;
  logic [2:0] addr_lo = 3'd0;
  logic dqm = 1'b0;
  logic [3:0] cmd;
  logic err;
  logic [2:0] err_code;
  logic [3:0] bank_open;
  logic wr_mask, rd_hiz;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    string tag;
    int c, e, k, o, w, h;
  } exp_t;
  exp_t q[$];
  exp_t x;

  always #5 clk = ~clk;

  sdram_cmd_checker u_sdram_cmd_checker (
    .clk(clk), .rst_n(rst_n), .cke_prev(cke_prev), .cke(cke), .cs_n(cs_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10),
    .addr_lo(addr_lo), .dqm(dqm), .cmd(cmd), .err(err), .err_code(err_code),
    .bank_open(bank_open), .wr_mask(wr_mask), .rd_hiz(rd_hiz));

  task automatic chk(string tag, string f, int act, int exp);
    if (exp >= 0) begin
      checks++;
      if (act != exp) begin
        errors++;
        $display("FAIL %s %s: actual %0d expected %0d", tag, f, act, exp);
      end
    end
  endtask

  always begin
    @(negedge clk);
    #3;
    if (q.size() > 0) begin
      x = q.pop_front();
      chk(x.tag, "cmd", int'(cmd), x.c);
      chk(x.tag, "err", int'(err), x.e);
      chk(x.tag, "err_code", int'(err_code), x.k);
      chk(x.tag, "bank_open", int'(bank_open), x.o);
      chk(x.tag, "wr_mask", int'(wr_mask), x.w);
      chk(x.tag, "rd_hiz", int'(rd_hiz), x.h);
    end
  end

  task automatic t(string tag, int op, logic [1:0] b, logic ap, logic [2:0] lo, logic dm,
                   int c, int e, int k, int o, int w, int h);
    exp_t it;
    @(negedge clk);
    cke_prev = 1'b1; cke = 1'b1; cs_n = 1'b0; {ras_n, cas_n, we_n} = 3'b111;
    ba = b; a10 = ap; addr_lo = lo; dqm = dm;
    case (op)
      DES:      cs_n = 1'b1;
      MRS:      {ras_n, cas_n, we_n} = 3'b000;
      REF:      {ras_n, cas_n, we_n} = 3'b001;
      ACT:      {ras_n, cas_n, we_n} = 3'b011;
      RD:       {ras_n, cas_n, we_n} = 3'b101;
      WR:       {ras_n, cas_n, we_n} = 3'b100;
      BST:      {ras_n, cas_n, we_n} = 3'b110;
      PRE:      {ras_n, cas_n, we_n} = 3'b010;
      SIN:      begin cke = 1'b0; {ras_n, cas_n, we_n} = 3'b001; end
      SOUT:     begin cke_prev = 1'b0; cs_n = 1'b1; end
      OTH:      begin cke_prev = 1'b0; cke = 1'b0; end
      SOUT_BAD: begin cke_prev = 1'b0; {ras_n, cas_n, we_n} = 3'b011; end
      default:  ;
    endcase
    it.tag = tag; it.c = c; it.e = e; it.k = k; it.o = o; it.w = w; it.h = h;
    q.push_back(it);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cke_prev = 1'b1; cke = 1'b1; cs_n = 1'b0; {ras_n, cas_n, we_n} = 3'b111; dqm = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state, R1 decode
    t("R9 R1 reset desel", DES, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    t("R1 nop", NOP, 0, 0, 0, 0, 1, 0, 0, 0, -1, -1);
    t("R12 R1 mode set bl4", MRS, 0, 0, 3'b010, 0, 2, 0, 0, 0, -1, -1);
    t("R5 lock nop", NOP, 0, 0, 0, 0, 1, 0, -1, -1, -1, -1);
    t("R5 lock nop", NOP, 0, 0, 0, 0, 1, 0, -1, -1, -1, -1);
    t("R5 act after lock", ACT, 2'b01, 0, 0, 0, 4, 0, 0, 0, -1, -1);
    t("R2 bank C bit2", NOP, 0, 0, 0, 0, 1, 0, 0, 4'b0100, -1, -1);
    t("R2 act bank B", ACT, 2'b10, 0, 0, 0, 4, 0, 0, 4'b0100, -1, -1);
    t("R10 write dqm", WR, 2'b01, 0, 0, 1, 6, 0, 0, 4'b0110, 1, -1);
    t("R10 beat2 dqm0", NOP, 0, 0, 0, 0, 1, 0, -1, -1, 0, -1);
    t("R10 beat3 dqm1", NOP, 0, 0, 0, 1, 1, 0, -1, -1, 1, -1);
    t("R10 beat4 dqm0", NOP, 0, 0, 0, 0, 1, 0, -1, -1, 0, -1);
    t("R12 R10 burst over", NOP, 0, 0, 0, 1, 1, 0, -1, -1, 0, 0);
    t("R11 read dqm1", RD, 2'b10, 0, 0, 1, 5, 0, 0, -1, 0, 0);
    t("R11 read beat2", NOP, 0, 0, 0, 0, 1, -1, -1, -1, 0, 0);
    t("R11 R10 hiz +2", NOP, 0, 0, 0, 1, 1, -1, -1, -1, 0, 1);
    t("R11 no hiz", NOP, 0, 0, 0, 0, 1, -1, -1, -1, 0, 0);
    t("R11 hiz +2 again", NOP, 0, 0, 0, 0, 1, -1, -1, -1, 0, 1);
    t("R11 idle dqm1", NOP, 0, 0, 0, 1, 1, -1, -1, -1, 0, 0);
    t("R11 quiet", NOP, 0, 0, 0, 0, 1, -1, -1, -1, -1, 0);
    t("R11 dqm outside read", NOP, 0, 0, 0, 0, 1, 0, -1, -1, -1, 0);
    t("R3 R1 precharge C", PRE, 2'b01, 0, 0, 0, 8, 0, 0, 4'b0110, -1, -1);
    t("R3 single bank closed", NOP, 0, 0, 0, 0, 1, 0, 0, 4'b0010, -1, -1);
    t("R2 act bank D", ACT, 2'b11, 0, 0, 0, 4, 0, 0, -1, -1, -1);
    t("R2 bank D bit3", NOP, 0, 0, 0, 0, 1, 0, 0, 4'b1010, -1, -1);
    t("R3 precharge all", PRE, 2'b00, 1, 0, 0, 8, 0, 0, -1, -1, -1);
    t("R3 all closed", NOP, 0, 0, 0, 0, 1, 0, 0, 0, -1, -1);
    t("R4 R1 refresh idle", REF, 0, 0, 0, 0, 3, 0, 0, 0, -1, -1);
    t("R4 R1 burst stop", BST, 0, 0, 0, 0, 7, 0, 0, 0, -1, -1);
    t("R4 act C", ACT, 2'b01, 0, 0, 0, 4, 0, 0, -1, -1, -1);
    t("R4 refresh open", REF, 0, 0, 0, 0, 3, 0, 0, 4'b0100, -1, -1);
    t("R4 err code1", RD, 2'b00, 0, 0, 0, 5, 1, 1, 4'b0100, -1, -1);
    t("R9 first code kept", NOP, 0, 0, 0, 0, 1, 1, 1, 4'b0100, -1, -1);

    do_reset();
    t("R5 mode set", MRS, 0, 0, 3'b000, 0, 2, 0, 0, 0, -1, -1);
    t("R5 nop", NOP, 0, 0, 0, 0, 1, 0, -1, -1, -1, -1);
    t("R5 act in lock", ACT, 2'b00, 0, 0, 0, 4, 0, 0, 0, -1, -1);
    t("R5 R9 code2 no effect", NOP, 0, 0, 0, 0, 1, 1, 2, 0, -1, -1);

    do_reset();
    t("R6 mode set bl4", MRS, 0, 0, 3'b010, 0, 2, 0, 0, -1, -1, -1);
    t("R6 nop", NOP, 0, 0, 0, 0, 1, -1, -1, -1, -1, -1);
    t("R6 nop", NOP, 0, 0, 0, 0, 1, -1, -1, -1, -1, -1);
    t("R6 act A", ACT, 2'b00, 0, 0, 0, 4, 0, -1, -1, -1, -1);
    t("R6 act D", ACT, 2'b11, 0, 0, 0, 4, 0, -1, -1, -1, -1);
    t("R6 read A autopre", RD, 2'b00, 1, 0, 0, 5, 0, 0, 4'b1001, -1, -1);
    t("R6 beat2", NOP, 0, 0, 0, 0, 1, 0, 0, 4'b1001, -1, -1);
    t("R6 beat3", NOP, 0, 0, 0, 0, 1, 0, 0, 4'b1001, -1, -1);
    t("R6 beat4 bank held", NOP, 0, 0, 0, 0, 1, 0, 0, 4'b1001, -1, -1);
    t("R6 read D after end", RD, 2'b11, 0, 0, 0, 5, 0, 0, 4'b1000, -1, -1);
    t("R6 legal", NOP, 0, 0, 0, 0, 1, 0, 0, -1, -1, -1);
    t("R7 wait", NOP, 0, 0, 0, 0, 1, 0, 0, -1, -1, -1);
    t("R7 act A at tRP", ACT, 2'b00, 0, 0, 0, 4, 0, 0, 4'b1000, -1, -1);
    t("R7 legal at tRP", NOP, 0, 0, 0, 0, 1, 0, 0, 4'b1001, -1, -1);
    t("R6 write A autopre", WR, 2'b00, 1, 0, 0, 6, 0, 0, -1, -1, -1);
    t("R6 write during ap", WR, 2'b11, 0, 0, 0, 6, 0, 0, -1, -1, -1);
    t("R6 code3", NOP, 0, 0, 0, 0, 1, 1, 3, -1, -1, -1);

    do_reset();
    t("R7 act A", ACT, 2'b00, 0, 0, 0, 4, 0, 0, 0, -1, -1);
    t("R7 R12 read bl1 autopre", RD, 2'b00, 1, 0, 0, 5, 0, 0, 4'b0001, -1, -1);
    t("R7 act early", ACT, 2'b00, 0, 0, 0, 4, 0, 0, 0, -1, -1);
    t("R7 code4", NOP, 0, 0, 0, 0, 1, 1, 4, 0, -1, -1);

    do_reset();
    t("R8 read idle", RD, 2'b10, 0, 0, 0, 5, 0, 0, 0, -1, -1);
    t("R8 code5", NOP, 0, 0, 0, 0, 1, 1, 5, 0, -1, -1);

    do_reset();
    t("R8 act D", ACT, 2'b11, 0, 0, 0, 4, 0, 0, 0, -1, -1);
    t("R8 act open", ACT, 2'b11, 0, 0, 0, 4, 0, 0, 4'b1000, -1, -1);
    t("R8 code6", NOP, 0, 0, 0, 0, 1, 1, 6, 4'b1000, -1, -1);

    do_reset();
    t("R13 sref entry", SIN, 0, 0, 0, 0, 9, 0, 0, 0, -1, -1);
    t("R13 cke held low", OTH, 0, 0, 0, 0, 11, 0, 0, -1, -1, -1);
    t("R13 sref exit", SOUT, 0, 0, 0, 0, 10, 0, 0, -1, -1, -1);
    t("R13 exit legal", NOP, 0, 0, 0, 0, 1, 0, 0, 0, -1, -1);
    t("R13 sref entry2", SIN, 0, 0, 0, 0, 9, 0, 0, -1, -1, -1);
    t("R13 bad exit", SOUT_BAD, 0, 0, 0, 0, 10, 0, 0, -1, -1, -1);
    t("R13 code7", NOP, 0, 0, 0, 0, 1, 1, 7, 0, -1, -1);

    do_reset();
    t("R13 act A", ACT, 2'b00, 0, 0, 0, 4, 0, 0, -1, -1, -1);
    t("R13 R4 entry open", SIN, 0, 0, 0, 0, 9, 0, 0, 4'b0001, -1, -1);
    t("R13 R4 code1", NOP, 0, 0, 0, 0, 1, 1, 1, 4'b0001, -1, -1);

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule